// File: doc/BRIEF.md
# I2C Hot-Swap Link Controller

This block is the digital control core of a two-segment I2C/SMBus buffer used for live card insertion. It observes the logic levels of SDA and SCL on the card-facing (input) segment and on the backplane-facing (output) segment. From these levels it decides when the two segments may be joined. It drives a link control, a ready flag and an active-low fault flag. Analog buffering, precharge and edge acceleration are handled elsewhere and are outside this block.

When the segments are joined and an output line stays low for a full timeout window (30 ms at 125 MHz by default), the block opens the link and lowers the fault flag. It then forces output SCL low in a short burst of clock pulses, up to a fixed count, to free a slave that is holding SDA. The link is joined again once the bus is seen free, either after a stop condition on the input segment or after a run of idle cycles, and that join clears the fault. The default pulse timing (5 µs low, 5 µs released) keeps the recovery clock at 100 kHz, well inside the 400 kHz operating range.

Top module: `hsw_link_ctrl`

## Requirements
- R1: After reset, connect_o and ready_o are 0, fault_n_o is 1 and scl_force_low_o is 0.
- R2: While the link is open and enable_i is 1, the link joins on the clock edge where all four lines are high and have also been high on the IDLE_CYCLES edges before it. connect_o then reads 1 from the following cycle.
- R3: While the link is open and enable_i is 1, a stop condition joins the link on that same edge. A stop condition is sda_in_i sampled 1 after a 0 sample, with scl_in_i, sda_out_i and scl_out_i all 1.
- R4: connect_o is 0 in any cycle where enable_i is 0, with no register delay, and the link never joins while enable_i is 0.
- R5: ready_o equals connect_o in every cycle.
- R6: While joined, if sda_out_i or scl_out_i is low on TIMEOUT_CYCLES consecutive edges, the link opens and fault_n_o goes to 0 on the last of those edges. Any edge with both output lines high restarts the count.
- R7: Recovery starts on the timeout edge. Each pulse holds scl_force_low_o at 1 for HALF_CYCLES cycles and then at 0 for HALF_CYCLES cycles. No more than PULSE_MAX pulses are issued.
- R8: If sda_out_i is 1 at the last cycle of a pulse's released half, recovery ends there and no further pulses are issued.
- R9: After recovery the link rejoins under the R2 or R3 rule, and fault_n_o returns to 1 on that joining edge, and not before it.
- R10: While fault_n_o is 0, it stays 0 through any change of enable_i until a join occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Permits joining; 0 opens the link at once |
| sda_in_i | input | 1 | Sampled SDA level, card segment |
| scl_in_i | input | 1 | Sampled SCL level, card segment |
| sda_out_i | input | 1 | Sampled SDA level, backplane segment |
| scl_out_i | input | 1 | Sampled SCL level, backplane segment |
| connect_o | output | 1 | 1 while the segments are joined |
| ready_o | output | 1 | Joined indication, same timing as connect_o |
| fault_n_o | output | 1 | 0 after a stuck-low timeout, until the next join |
| scl_force_low_o | output | 1 | 1 while output SCL is to be pulled low for recovery |

## Verification
connect_o and ready_o follow enable_i in the same cycle. Join, timeout, fault and pulse changes take effect on the clock edge after the deciding sample, so they are visible one cycle after that sample. Stimulus is applied just after the falling edge. Directed checks read the outputs in that same half-cycle, after the number of rising edges that each requirement counts. A behavioural reference model advances on every rising edge and is compared with all four outputs a few nanoseconds after each falling edge. Recovery pulses are timed by counting consecutive low samples, so both pulse width and pulse count are checked against HALF_CYCLES and PULSE_MAX.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [1:0] {
        LINK_OPEN    = 2'd0,
        LINK_JOINED  = 2'd1,
        LINK_RECOVER = 2'd2
    } link_state_e;

endpackage

// File: rtl/hsw_bus_watch.sv
module hsw_bus_watch #(
    parameter int IDLE_CYCLES = 1250
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sda_in_i,
    input  logic scl_in_i,
    input  logic sda_out_i,
    input  logic scl_out_i,
    output logic idle_ok_o,
    output logic stop_ok_o
);
    localparam int IW = $clog2(IDLE_CYCLES + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYCLES);

    typedef struct packed {
        logic [IW-1:0] idle_cnt;
        logic          sda_in_prev;
    } watch_t;

    watch_t watch_d, watch_q;
    logic   all_high;

    assign all_high = sda_in_i & scl_in_i & sda_out_i & scl_out_i;

    always_comb begin
        watch_d = watch_q;
        if (!all_high) begin
            watch_d.idle_cnt = '0;
        end else if (watch_q.idle_cnt != IDLE_LAST) begin
            watch_d.idle_cnt = watch_q.idle_cnt + 1'b1;
        end
        watch_d.sda_in_prev = sda_in_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            watch_q.idle_cnt    <= '0;
            watch_q.sda_in_prev <= 1'b1;
        end else begin
            watch_q <= watch_d;
        end
    end

    // quiet long enough, and still quiet on this sample
    assign idle_ok_o = all_high && (watch_q.idle_cnt == IDLE_LAST);
    // SDA rising on the card side while clock and backplane lines are high
    assign stop_ok_o = sda_in_i && !watch_q.sda_in_prev && scl_in_i
                       && sda_out_i && scl_out_i;
endmodule

// File: rtl/hsw_stuck_timer.sv
module hsw_stuck_timer #(
    parameter int TIMEOUT_CYCLES = 3750000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic sda_out_i,
    input  logic scl_out_i,
    output logic expire_o
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t timer_d, timer_q;
    logic   held_low;

    assign held_low = !sda_out_i || !scl_out_i;
    assign expire_o = arm_i && held_low && (timer_q.cnt == CNT_LAST);

    always_comb begin
        timer_d = timer_q;
        if (!arm_i || !held_low || expire_o) begin
            timer_d.cnt = '0;
        end else begin
            timer_d.cnt = timer_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            timer_q.cnt <= '0;
        end else begin
            timer_q <= timer_d;
        end
    end
endmodule

// File: rtl/hsw_recovery_clk.sv
module hsw_recovery_clk #(
    parameter int HALF_CYCLES = 625,
    parameter int PULSE_MAX   = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic sda_out_i,
    output logic scl_low_o,
    output logic done_o
);
    localparam int HW = $clog2(HALF_CYCLES + 1);
    localparam int PW = $clog2(PULSE_MAX + 1);
    localparam logic [HW-1:0] PHASE_LAST = HW'(HALF_CYCLES - 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_MAX - 1);

    typedef struct packed {
        logic          active;
        logic          low;
        logic [HW-1:0] phase;
        logic [PW-1:0] pulses;
    } rec_t;

    rec_t rec_d, rec_q;
    logic phase_end;

    assign phase_end = (rec_q.phase == PHASE_LAST);
    assign done_o    = rec_q.active && !rec_q.low && phase_end
                       && (sda_out_i || (rec_q.pulses == PULSE_LAST));
    assign scl_low_o = rec_q.active && rec_q.low;

    always_comb begin
        rec_d = rec_q;
        if (start_i) begin
            rec_d.active = 1'b1;
            rec_d.low    = 1'b1;
            rec_d.phase  = '0;
            rec_d.pulses = '0;
        end else if (rec_q.active) begin
            if (phase_end) begin
                rec_d.phase = '0;
                if (rec_q.low) begin
                    rec_d.low = 1'b0;
                end else if (done_o) begin
                    rec_d.active = 1'b0;
                end else begin
                    rec_d.pulses = rec_q.pulses + 1'b1;
                    rec_d.low    = 1'b1;
                end
            end else begin
                rec_d.phase = rec_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end
endmodule

// File: rtl/hsw_link_ctrl.sv
module hsw_link_ctrl
    import hsw_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 3750000,
    parameter int IDLE_CYCLES    = 1250,
    parameter int HALF_CYCLES    = 625,
    parameter int PULSE_MAX      = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic sda_in_i,
    input  logic scl_in_i,
    input  logic sda_out_i,
    input  logic scl_out_i,
    output logic connect_o,
    output logic ready_o,
    output logic fault_n_o,
    output logic scl_force_low_o
);
    typedef struct packed {
        link_state_e state;
        logic        fault_n;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  idle_ok, stop_ok, expire, rec_start, rec_done, timer_arm;

    hsw_bus_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sda_in_i  (sda_in_i),
        .scl_in_i  (scl_in_i),
        .sda_out_i (sda_out_i),
        .scl_out_i (scl_out_i),
        .idle_ok_o (idle_ok),
        .stop_ok_o (stop_ok)
    );

    assign timer_arm = (ctrl_q.state == LINK_JOINED) && enable_i;

    hsw_stuck_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .arm_i     (timer_arm),
        .sda_out_i (sda_out_i),
        .scl_out_i (scl_out_i),
        .expire_o  (expire)
    );

    hsw_recovery_clk #(
        .HALF_CYCLES (HALF_CYCLES),
        .PULSE_MAX   (PULSE_MAX)
    ) u_recovery (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (rec_start),
        .sda_out_i (sda_out_i),
        .scl_low_o (scl_force_low_o),
        .done_o    (rec_done)
    );

    always_comb begin
        ctrl_d    = ctrl_q;
        rec_start = 1'b0;
        unique case (ctrl_q.state)
            LINK_OPEN: begin
                if (enable_i && (idle_ok || stop_ok)) begin
                    ctrl_d.state   = LINK_JOINED;
                    ctrl_d.fault_n = 1'b1;
                end
            end
            LINK_JOINED: begin
                if (!enable_i) begin
                    ctrl_d.state = LINK_OPEN;
                end else if (expire) begin
                    ctrl_d.state   = LINK_RECOVER;
                    ctrl_d.fault_n = 1'b0;
                    rec_start      = 1'b1;
                end
            end
            LINK_RECOVER: begin
                if (rec_done) begin
                    ctrl_d.state = LINK_OPEN;
                end
            end
            default: ctrl_d.state = LINK_OPEN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q.state   <= LINK_OPEN;
            ctrl_q.fault_n <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign connect_o = (ctrl_q.state == LINK_JOINED) && enable_i;
    assign ready_o   = connect_o;
    assign fault_n_o = ctrl_q.fault_n;
endmodule

// File: rtl/hsw_link_ctrl_chk.sv
module hsw_link_ctrl_chk #(
    parameter int PULSE_MAX = 16
) (
    input logic clk_i,
    input logic rst_ni,
    input logic enable_i,
    input logic connect_o,
    input logic ready_o,
    input logic fault_n_o,
    input logic scl_force_low_o
);
    int   pulse_cnt;
    logic low_prev;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pulse_cnt <= 0;
            low_prev  <= 1'b0;
        end else begin
            low_prev <= scl_force_low_o;
            if (connect_o) begin
                pulse_cnt <= 0;
            end else if (scl_force_low_o && !low_prev) begin
                pulse_cnt <= pulse_cnt + 1;
            end
        end
    end

    assert_join_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        connect_o |-> enable_i);

    assert_ready_tracks_link_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o == connect_o);

    assert_fault_opens_link_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(fault_n_o) |-> !connect_o);

    assert_pulses_while_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_force_low_o |-> !connect_o);

    assert_pulse_budget_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_cnt <= PULSE_MAX);

    assert_fault_clears_on_join_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fault_n_o) |-> connect_o);

    assert_fault_held_when_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fault_n_o && !enable_i) |=> !fault_n_o);
endmodule

bind hsw_link_ctrl hsw_link_ctrl_chk #(.PULSE_MAX(PULSE_MAX)) i_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .enable_i        (enable_i),
    .connect_o       (connect_o),
    .ready_o         (ready_o),
    .fault_n_o       (fault_n_o),
    .scl_force_low_o (scl_force_low_o)
);

// File: tb/test_hsw_link_ctrl.sv
`timescale 1ns/1ps
module test_hsw_link_ctrl;
    localparam int TO   = 200;
    localparam int IDLE = 8;
    localparam int HALF = 5;
    localparam int PMAX = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic sda_in = 1'b1, scl_in = 1'b1, sda_out = 1'b1, scl_out = 1'b1;
    logic connect, ready, fault_n, scl_low;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hsw_link_ctrl #(
        .TIMEOUT_CYCLES (TO),
        .IDLE_CYCLES    (IDLE),
        .HALF_CYCLES    (HALF),
        .PULSE_MAX      (PMAX)
    ) i_hsw_link_ctrl (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .enable_i        (enable),
        .sda_in_i        (sda_in),
        .scl_in_i        (scl_in),
        .sda_out_i       (sda_out),
        .scl_out_i       (scl_out),
        .connect_o       (connect),
        .ready_o         (ready),
        .fault_n_o       (fault_n),
        .scl_force_low_o (scl_low)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 open, 1 joined, 2 recovering
    int m_state, m_idle, m_stuck, m_phase, m_pulses;
    bit m_fault_n, m_prev, m_low;
    bit t_all, t_idle, t_stop, t_held, t_exp, t_done;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_fault_n = 1; m_idle = 0; m_prev = 1;
            m_stuck = 0; m_low = 0; m_phase = 0; m_pulses = 0;
        end else begin
            t_all  = sda_in && scl_in && sda_out && scl_out;
            t_idle = t_all && (m_idle == IDLE);
            t_stop = sda_in && !m_prev && scl_in && sda_out && scl_out;
            t_held = !sda_out || !scl_out;
            t_exp  = (m_state == 1) && enable && t_held && (m_stuck == TO - 1);
            t_done = (m_state == 2) && !m_low && (m_phase == HALF - 1)
                     && (sda_out || (m_pulses == PMAX - 1));
            if (!t_all) m_idle = 0;
            else if (m_idle < IDLE) m_idle = m_idle + 1;
            m_prev = sda_in;
            if ((m_state == 1) && enable && t_held && !t_exp) m_stuck = m_stuck + 1;
            else m_stuck = 0;
            if (m_state == 0) begin
                if (enable && (t_idle || t_stop)) begin m_state = 1; m_fault_n = 1; end
            end else if (m_state == 1) begin
                if (!enable) m_state = 0;
                else if (t_exp) begin
                    m_state = 2; m_fault_n = 0; m_low = 1; m_phase = 0; m_pulses = 0;
                end
            end else begin
                if (m_phase == HALF - 1) begin
                    m_phase = 0;
                    if (m_low) m_low = 0;
                    else if (t_done) m_state = 0;
                    else begin m_pulses = m_pulses + 1; m_low = 1; end
                end else begin
                    m_phase = m_phase + 1;
                end
            end
        end
    end

    // per-cycle comparison, 3 ns after the falling edge
    always begin
        @(negedge clk);
        #3;
        if (rst_n && !finished) begin
            chk("R2 model connect", int'(connect), int'((m_state == 1) && enable));
            chk("R5 model ready",   int'(ready),   int'((m_state == 1) && enable));
            chk("R6 model fault_n", int'(fault_n), int'(m_fault_n));
            chk("R7 model scl_low", int'(scl_low), int'((m_state == 2) && m_low));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic count_pulses(input int cycles, input int stop_after,
                                output int rises, output int min_run, output int max_run);
        bit prev_s = 1'b0;
        int run = 0;
        rises = 0; min_run = 9999; max_run = 0;
        for (int i = 0; i < cycles; i++) begin
            if (scl_low && !prev_s) begin
                rises++;
                if (rises == stop_after) sda_out = 1'b1;
            end
            if (scl_low) run++;
            else if (prev_s) begin
                if (run < min_run) min_run = run;
                if (run > max_run) max_run = run;
                run = 0;
            end
            prev_s = scl_low;
            cyc(1);
        end
    endtask

    initial begin
        int rises, mn, mx;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 reset connect", int'(connect), 0);
        chk("R1 reset ready",   int'(ready),   0);
        chk("R1 reset fault_n", int'(fault_n), 1);
        chk("R1 reset scl_low", int'(scl_low), 0);

        // bus idle but enable low
        cyc(20);
        chk("R4 no join while disabled", int'(connect), 0);

        // idle already satisfied: join on next edge
        enable = 1'b1;
        cyc(1);
        chk("R2 idle join", int'(connect), 1);
        chk("R5 ready with link", int'(ready), 1);

        // enable low opens at once
        enable = 1'b0;
        #1;
        chk("R4 immediate open connect", int'(connect), 0);
        chk("R4 immediate open ready",   int'(ready),   0);

        // stop condition join
        sda_in = 1'b0;
        cyc(3);
        enable = 1'b1;
        cyc(3);
        chk("R3 no join before stop", int'(connect), 0);
        sda_in = 1'b1;
        cyc(1);
        chk("R3 stop join", int'(connect), 1);

        // stuck low with one interruption
        sda_out = 1'b0;
        cyc(TO - 10);
        sda_out = 1'b1;
        cyc(1);
        sda_out = 1'b0;
        cyc(TO - 1);
        chk("R6 count restarted, still joined", int'(connect), 1);
        chk("R6 count restarted, no fault",     int'(fault_n), 1);
        cyc(1);
        chk("R6 timeout opens link", int'(connect), 0);
        chk("R6 timeout fault",      int'(fault_n), 0);

        // full burst with SDA held low
        count_pulses(2 * HALF * PMAX + 40, 0, rises, mn, mx);
        chk("R7 pulse count", rises, PMAX);
        chk("R7 min low width", mn, HALF);
        chk("R7 max low width", mx, HALF);

        // fault holds across enable changes
        enable = 1'b0;
        cyc(5);
        chk("R10 fault held, disabled", int'(fault_n), 0);
        enable = 1'b1;
        cyc(5);
        chk("R10 fault held, bus busy", int'(fault_n), 0);
        chk("R10 still open", int'(connect), 0);

        // bus released: idle rejoin clears fault
        sda_out = 1'b1;
        cyc(IDLE);
        chk("R9 not yet joined", int'(connect), 0);
        chk("R9 fault before join", int'(fault_n), 0);
        cyc(1);
        chk("R9 rejoin", int'(connect), 1);
        chk("R9 fault cleared", int'(fault_n), 1);

        // second stuck event, SDA freed during third pulse
        sda_out = 1'b0;
        cyc(TO);
        chk("R6 second timeout fault", int'(fault_n), 0);
        count_pulses(2 * HALF * PMAX + 40, 3, rises, mn, mx);
        chk("R8 early stop pulse count", rises, 3);
        chk("R9 rejoin after early stop", int'(connect), 1);
        chk("R9 fault cleared after early stop", int'(fault_n), 1);
        chk("R5 ready after rejoin", int'(ready), 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule